// File: doc/BRIEF.md
# Data-Capture Reservation Station

This block parks dispatched instructions in a small pool of slots until every source operand is in hand, then hands them one at a time to a single functional unit. At dispatch each source comes in either as a finished value or as the tag of the instruction that will produce it. Every slot watches the result broadcast bus. When a broadcast tag equals a tag a slot is still waiting on, the slot copies the broadcast value into its own storage. Issue therefore carries the operand data itself, and no register file read is needed after issue.

Issue follows operand readiness, not program order. When several slots are ready, the one with the lowest index wins. A slot is freed as soon as its instruction moves into the registered issue stage. From that stage the instruction leaves under a valid/ready handshake toward the functional unit. Dispatch also uses a valid/ready handshake. The broadcast bus carries only a valid qualifier and is always accepted.

Top module: `rs_dcap_top`

## Requirements
- R1: After reset `iss_valid` is 0 and `dis_ready` is 1.
- R2: A dispatch is taken on a clock edge where `dis_valid` and `dis_ready` are both 1. `dis_ready` is 0 exactly when all ENTRIES slots are occupied, and a dispatch offered while it is 0 has no effect.
- R3: A source marked ready at dispatch (`dis_src_rdy[s]`=1) is issued with the dispatched value unchanged. Source s occupies bits [s*DATA_W +: DATA_W] of `dis_src_data` and of `iss_src_data`, and its tag occupies bits [s*TAG_W +: TAG_W] of `dis_src_tag`.
- R4: A waiting source captures `bc_data` on the first edge where `bc_valid`=1 and `bc_tag` equals its tag. A broadcast with any other tag leaves it waiting.
- R5: A broadcast on the same edge as the dispatch of a source waiting on that tag is captured, and the instruction issues with the broadcast value.
- R6: An instruction never reaches the issue port while any of its sources is still waiting.
- R7: A dispatch goes into the lowest-index free slot. When several slots are ready, the lowest-index ready slot is moved to the issue stage first.
- R8: While `iss_valid`=1 and `iss_ready`=0, `iss_valid`, `iss_op`, `iss_dst` and `iss_src_data` hold their values.
- R9: Moving an instruction into the issue stage frees its slot, and `dis_ready` returns to 1 once a slot is free.
- R10: A broadcast whose tag equals the tag field of a source that is already ready does not change that source's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_valid | input | 1 | Dispatch request |
| dis_ready | output | 1 | A free slot exists |
| dis_op | input | OP_W | Operation code |
| dis_dst | input | TAG_W | Destination tag |
| dis_src_rdy | input | NSRC | Per-source flag: value supplied |
| dis_src_tag | input | NSRC*TAG_W | Per-source producer tag |
| dis_src_data | input | NSRC*DATA_W | Per-source value |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| bc_data | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | Issue stage holds an instruction |
| iss_ready | input | 1 | Functional unit accepts |
| iss_op | output | OP_W | Issued operation code |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_src_data | output | NSRC*DATA_W | Issued operand values |

## Verification
A slot that misses a tag compare leaves its instruction stranded, so the expected issue never shows up and the bench waits only a bounded number of cycles before calling it a failure. A stale data field shows up as a wrong operand value on the issue port. Faults in the pickers show up as a wrong order of destination tags when several slots become ready out of index order. Occupancy faults show up at the port as `dis_ready` staying high when the pool is full, or as a rejected dispatch that later issues. All of these appear within a few cycles of the stimulus that exposes them.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // default geometry shared by the station and its checker
  localparam int RS_ENTRIES = 4;
  localparam int RS_NSRC    = 2;
  localparam int RS_TAG_W   = 4;
  localparam int RS_DATA_W  = 16;
  localparam int RS_OP_W    = 4;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int NSRC   = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc,
  input  logic [OP_W-1:0]        d_op,
  input  logic [TAG_W-1:0]       d_dst,
  input  logic [NSRC-1:0]        d_rdy,
  input  logic [NSRC*TAG_W-1:0]  d_tag,
  input  logic [NSRC*DATA_W-1:0] d_data,
  input  logic                   bc_valid,
  input  logic [TAG_W-1:0]       bc_tag,
  input  logic [DATA_W-1:0]      bc_data,
  input  logic                   release_i,
  output logic                   valid,
  output logic                   ready,
  output logic [OP_W-1:0]        op,
  output logic [TAG_W-1:0]       dst,
  output logic [NSRC*DATA_W-1:0] data
);
  logic [NSRC-1:0] src_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      op    <= '0;
      dst   <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      op    <= d_op;
      dst   <= d_dst;
    end else if (release_i) begin
      valid <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic [TAG_W-1:0]  new_tag;
    logic              hit_new;
    logic              hit_old;

    assign new_tag = d_tag[s*TAG_W +: TAG_W];
    assign hit_new = bc_valid && (bc_tag == new_tag);
    assign hit_old = bc_valid && (bc_tag == tag_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        src_rdy[s] <= 1'b0;
        tag_q      <= '0;
        val_q      <= '0;
      end else if (alloc) begin
        tag_q <= new_tag;
        if (d_rdy[s]) begin
          src_rdy[s] <= 1'b1;
          val_q      <= d_data[s*DATA_W +: DATA_W];
        end else if (hit_new) begin
          src_rdy[s] <= 1'b1;
          val_q      <= bc_data;
        end else begin
          src_rdy[s] <= 1'b0;
        end
      end else if (valid && !src_rdy[s] && hit_old) begin
        src_rdy[s] <= 1'b1;
        val_q      <= bc_data;
      end
    end

    assign data[s*DATA_W +: DATA_W] = val_q;
  end

  assign ready = valid && (&src_rdy);
endmodule

// File: rtl/rs_issue_reg.sv
module rs_issue_reg #(
  parameter int ENTRIES = 4,
  parameter int NSRC    = 2,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ENTRIES-1:0]                   grant,
  input  logic                                 grant_any,
  input  logic [ENTRIES-1:0][OP_W-1:0]         ent_op,
  input  logic [ENTRIES-1:0][TAG_W-1:0]        ent_dst,
  input  logic [ENTRIES-1:0][NSRC*DATA_W-1:0]  ent_data,
  input  logic                                 iss_ready,
  output logic                                 take,
  output logic                                 iss_valid,
  output logic [OP_W-1:0]                      iss_op,
  output logic [TAG_W-1:0]                     iss_dst,
  output logic [NSRC*DATA_W-1:0]               iss_data
);
  logic [OP_W-1:0]        m_op;
  logic [TAG_W-1:0]       m_dst;
  logic [NSRC*DATA_W-1:0] m_data;
  logic                   slot_free;

  // one-hot AND-OR mux from the granted slot
  always_comb begin
    m_op   = '0;
    m_dst  = '0;
    m_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        m_op   = m_op   | ent_op[i];
        m_dst  = m_dst  | ent_dst[i];
        m_data = m_data | ent_data[i];
      end
    end
  end

  assign slot_free = !iss_valid || iss_ready;
  assign take      = grant_any && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_dst   <= '0;
      iss_data  <= '0;
    end else if (slot_free) begin
      iss_valid <= grant_any;
      if (grant_any) begin
        iss_op   <= m_op;
        iss_dst  <= m_dst;
        iss_data <= m_data;
      end
    end
  end
endmodule

// File: rtl/rs_dcap_top.sv
module rs_dcap_top #(
  parameter int ENTRIES = rs_pkg::RS_ENTRIES,
  parameter int NSRC    = rs_pkg::RS_NSRC,
  parameter int TAG_W   = rs_pkg::RS_TAG_W,
  parameter int DATA_W  = rs_pkg::RS_DATA_W,
  parameter int OP_W    = rs_pkg::RS_OP_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dis_valid,
  output logic                   dis_ready,
  input  logic [OP_W-1:0]        dis_op,
  input  logic [TAG_W-1:0]       dis_dst,
  input  logic [NSRC-1:0]        dis_src_rdy,
  input  logic [NSRC*TAG_W-1:0]  dis_src_tag,
  input  logic [NSRC*DATA_W-1:0] dis_src_data,
  input  logic                   bc_valid,
  input  logic [TAG_W-1:0]       bc_tag,
  input  logic [DATA_W-1:0]      bc_data,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic [OP_W-1:0]        iss_op,
  output logic [TAG_W-1:0]       iss_dst,
  output logic [NSRC*DATA_W-1:0] iss_src_data
);
  localparam int SRC_DW = NSRC * DATA_W;

  logic [ENTRIES-1:0]                ent_valid;
  logic [ENTRIES-1:0]                ent_rdy;
  logic [ENTRIES-1:0][OP_W-1:0]      ent_op;
  logic [ENTRIES-1:0][TAG_W-1:0]     ent_dst;
  logic [ENTRIES-1:0][SRC_DW-1:0]    ent_data;
  logic [ENTRIES-1:0]                free_gnt;
  logic                              free_any;
  logic [ENTRIES-1:0]                sel_grant;
  logic                              sel_any;
  logic                              take;
  logic [ENTRIES-1:0]                rel_mask;
  logic                              dis_fire;

  rs_prio_pick #(.N(ENTRIES)) u_alloc (
    .req (~ent_valid),
    .gnt (free_gnt),
    .any (free_any)
  );

  assign dis_ready = free_any;
  assign dis_fire  = dis_valid && free_any;

  rs_prio_pick #(.N(ENTRIES)) u_select (
    .req (ent_rdy),
    .gnt (sel_grant),
    .any (sel_any)
  );

  assign rel_mask = sel_grant & {ENTRIES{take}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    rs_entry #(
      .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)
    ) u_ent (
      .clk       (clk),
      .rst       (rst),
      .alloc     (dis_fire && free_gnt[i]),
      .d_op      (dis_op),
      .d_dst     (dis_dst),
      .d_rdy     (dis_src_rdy),
      .d_tag     (dis_src_tag),
      .d_data    (dis_src_data),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .release_i (rel_mask[i]),
      .valid     (ent_valid[i]),
      .ready     (ent_rdy[i]),
      .op        (ent_op[i]),
      .dst       (ent_dst[i]),
      .data      (ent_data[i])
    );
  end

  rs_issue_reg #(
    .ENTRIES(ENTRIES), .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)
  ) u_issue (
    .clk       (clk),
    .rst       (rst),
    .grant     (sel_grant),
    .grant_any (sel_any),
    .ent_op    (ent_op),
    .ent_dst   (ent_dst),
    .ent_data  (ent_data),
    .iss_ready (iss_ready),
    .take      (take),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .iss_dst   (iss_dst),
    .iss_data  (iss_src_data)
  );
endmodule

// File: rtl/rs_dcap_chk.sv
module rs_dcap_chk #(
  parameter int ENTRIES = 4,
  parameter int NSRC    = 2,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   dis_valid,
  input logic                   dis_ready,
  input logic                   iss_valid,
  input logic                   iss_ready,
  input logic [OP_W-1:0]        iss_op,
  input logic [TAG_W-1:0]       iss_dst,
  input logic [NSRC*DATA_W-1:0] iss_src_data,
  input logic [ENTRIES-1:0]     ent_valid,
  input logic [ENTRIES-1:0]     sel_grant,
  input logic [ENTRIES-1:0]     rel_mask
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!iss_valid && dis_ready));

  // R8
  issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=>
      (iss_valid && $stable(iss_op) && $stable(iss_dst) && $stable(iss_src_data)));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_grant));

  // R2
  dispatch_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_valid && dis_ready && (rel_mask == '0)) |=>
      ($countones(ent_valid) == $past($countones(ent_valid)) + 1));

  // R9
  issue_frees_chk: assert property (@(posedge clk) disable iff (rst)
    ((rel_mask != '0) && !(dis_valid && dis_ready)) |=>
      ($countones(ent_valid) + 1 == $past($countones(ent_valid))));
endmodule

bind rs_dcap_top rs_dcap_chk #(
  .ENTRIES(ENTRIES), .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .dis_valid    (dis_valid),
  .dis_ready    (dis_ready),
  .iss_valid    (iss_valid),
  .iss_ready    (iss_ready),
  .iss_op       (iss_op),
  .iss_dst      (iss_dst),
  .iss_src_data (iss_src_data),
  .ent_valid    (ent_valid),
  .sel_grant    (sel_grant),
  .rel_mask     (rel_mask)
);

// File: tb/tb_rs_dcap_top.sv
`timescale 1ns/1ps
module tb_rs_dcap_top;
  localparam int ENTRIES = 4;
  localparam int NSRC    = 2;
  localparam int TAG_W   = 4;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;

  logic clk = 1'b0;
  logic rst;
  logic dis_valid;
  logic dis_ready;
  logic [OP_W-1:0] dis_op;
  logic [TAG_W-1:0] dis_dst;
  logic [NSRC-1:0] dis_src_rdy;
  logic [NSRC*TAG_W-1:0] dis_src_tag;
  logic [NSRC*DATA_W-1:0] dis_src_data;
  logic bc_valid;
  logic [TAG_W-1:0] bc_tag;
  logic [DATA_W-1:0] bc_data;
  logic iss_valid;
  logic iss_ready;
  logic [OP_W-1:0] iss_op;
  logic [TAG_W-1:0] iss_dst;
  logic [NSRC*DATA_W-1:0] iss_src_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rs_dcap_top #(
    .ENTRIES(ENTRIES), .NSRC(NSRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)
  ) dut (
    .clk(clk), .rst(rst),
    .dis_valid(dis_valid), .dis_ready(dis_ready), .dis_op(dis_op), .dis_dst(dis_dst),
    .dis_src_rdy(dis_src_rdy), .dis_src_tag(dis_src_tag), .dis_src_data(dis_src_data),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src_data(iss_src_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all drive tasks start and end at a falling edge
  task automatic dispatch(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                          input logic [NSRC-1:0] rdy, input logic [TAG_W-1:0] t0,
                          input logic [TAG_W-1:0] t1, input logic [DATA_W-1:0] v0,
                          input logic [DATA_W-1:0] v1);
    dis_valid = 1'b1; dis_op = op; dis_dst = dst; dis_src_rdy = rdy;
    dis_src_tag = {t1, t0}; dis_src_data = {v1, v0};
    @(negedge clk);
    dis_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    bc_valid = 1'b1; bc_tag = t; bc_data = d;
    @(negedge clk);
    bc_valid = 1'b0;
  endtask

  task automatic expect_issue(input string req, input logic [OP_W-1:0] op,
                              input logic [TAG_W-1:0] dst,
                              input logic [NSRC*DATA_W-1:0] data);
    bit seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      @(negedge clk);
      if (iss_valid) seen = 1;
    end
    check(seen, req, {63'b0, iss_valid}, 64'd1);
    if (seen) begin
      check(iss_dst == dst, req, iss_dst, dst);
      check(iss_op == op, req, iss_op, op);
      check(iss_src_data == data, req, iss_src_data, data);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dis_valid = 0; dis_op = 0; dis_dst = 0; dis_src_rdy = 0;
    dis_src_tag = 0; dis_src_data = 0; bc_valid = 0; bc_tag = 0; bc_data = 0;
    iss_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(iss_valid == 1'b0, "R1 iss_valid", iss_valid, 0);
    check(dis_ready == 1'b1, "R1 dis_ready", dis_ready, 1);

    // R3 R4 R6 sweep over which sources arrive ready
    for (int m = 0; m < 4; m++) begin
      logic [DATA_W-1:0] rv0, rv1, bv0, bv1, e0, e1;
      rv0 = DATA_W'(16'h1000 + m*16'h10);
      rv1 = DATA_W'(16'h1001 + m*16'h10);
      bv0 = DATA_W'(16'h2000 + m*16'h10);
      bv1 = DATA_W'(16'h2001 + m*16'h10);
      e0 = m[0] ? rv0 : bv0;
      e1 = m[1] ? rv1 : bv1;
      dispatch(OP_W'(m + 1), TAG_W'(m + 4), NSRC'(m), 4'd1, 4'd2, rv0, rv1);
      if (m == 3) begin
        expect_issue("R3 all ready", OP_W'(m + 1), TAG_W'(m + 4), {e1, e0});
      end else begin
        repeat (3) @(negedge clk);
        check(iss_valid == 1'b0, "R6 waiting not issued", iss_valid, 0);
        bcast(4'd7, 16'hBAD0);
        repeat (2) @(negedge clk);
        check(iss_valid == 1'b0, "R4 foreign tag ignored", iss_valid, 0);
        if (!m[0]) bcast(4'd1, bv0);
        if (m == 0) begin
          repeat (2) @(negedge clk);
          check(iss_valid == 1'b0, "R6 one source still waiting", iss_valid, 0);
        end
        if (!m[1]) bcast(4'd2, bv1);
        expect_issue("R4 captured issue", OP_W'(m + 1), TAG_W'(m + 4), {e1, e0});
      end
      repeat (2) @(negedge clk);
    end

    // R5 broadcast coincident with dispatch
    dis_valid = 1'b1; dis_op = 4'd9; dis_dst = 4'd3; dis_src_rdy = 2'b10;
    dis_src_tag = {4'd0, 4'd5}; dis_src_data = {16'h3333, 16'h0000};
    bc_valid = 1'b1; bc_tag = 4'd5; bc_data = 16'h5A5A;
    @(negedge clk);
    dis_valid = 1'b0; bc_valid = 1'b0;
    expect_issue("R5 same-cycle capture", 4'd9, 4'd3, {16'h3333, 16'h5A5A});
    repeat (2) @(negedge clk);

    // R10 broadcast matching a stale tag of a ready source
    dispatch(4'd6, 4'd2, 2'b01, 4'd5, 4'd6, 16'h1111, 16'h0000);
    bcast(4'd5, 16'hDEAD);
    bcast(4'd6, 16'h2222);
    expect_issue("R10 ready source kept", 4'd6, 4'd2, {16'h2222, 16'h1111});
    repeat (2) @(negedge clk);

    // R2 R7 R8 R9 fill the pool, release out of index order
    iss_ready = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      dispatch(OP_W'(i + 1), TAG_W'(8 + i), 2'b10, TAG_W'(i + 1), 4'd0,
               16'h0000, DATA_W'(16'hA000 + i));
    check(dis_ready == 1'b0, "R2 full", dis_ready, 0);
    dis_valid = 1'b1; dis_op = 4'hF; dis_dst = 4'hF; dis_src_rdy = 2'b11;
    dis_src_data = {16'hFFFF, 16'hFFFF};
    repeat (2) @(negedge clk);
    dis_valid = 1'b0;
    bcast(4'd4, 16'hC044);
    bcast(4'd2, 16'hC022);
    bcast(4'd1, 16'hC011);
    bcast(4'd3, 16'hC033);
    check(iss_valid == 1'b1 && iss_dst == 4'd11, "R7 first ready", iss_dst, 11);
    repeat (3) @(negedge clk);
    check(iss_valid == 1'b1 && iss_dst == 4'd11 && iss_src_data == {16'hA003, 16'hC044},
          "R8 hold under stall", iss_src_data, {16'hA003, 16'hC044});
    iss_ready = 1'b1;
    @(negedge clk);
    check(iss_dst == 4'd8, "R7 lowest index next", iss_dst, 8);
    check(iss_src_data == {16'hA000, 16'hC011}, "R7 data entry0", iss_src_data,
          {16'hA000, 16'hC011});
    @(negedge clk);
    check(iss_dst == 4'd9, "R7 order entry1", iss_dst, 9);
    @(negedge clk);
    check(iss_dst == 4'd10, "R7 order entry2", iss_dst, 10);
    check(iss_src_data == {16'hA002, 16'hC033}, "R7 data entry2", iss_src_data,
          {16'hA002, 16'hC033});
    repeat (4) @(negedge clk);
    check(iss_valid == 1'b0, "R2 rejected dispatch absent", iss_valid, 0);
    check(dis_ready == 1'b1, "R9 slots freed", dis_ready, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule